// File: doc/BRIEF.md
# Sixteen-bit accumulator CPU core

This block is a single-cycle processor core with a 16-bit datapath and separate ports for instruction fetch and data memory. It keeps an address register, a data register and a 15-bit program counter. Every clock it decodes the word on the instruction port and retires it. When the top bit is clear, the word is an immediate that goes into the address register. When the top bit is set, the word is a compute word. A compute word runs the ALU on the data register and on either the address register or the data memory input. It stores the result in any mix of the address register, the data register and memory, and it may branch to the address held in the address register.

The instruction store and the data store sit outside the core. The program counter addresses the instruction store. The low 15 bits of the address register address the data store. The ALU result is the write data, and a write strobe marks each store. Reset is synchronous. It clears the counter and both registers and suppresses the write strobe.

Top module: `acc16_core`

## Requirements
- R1: While `rst` is high, `mem_we` stays low for any instruction. On the edge that sees `rst`, `pc_q`, the address register and the data register are cleared, so `mem_addr` reads 0 after reset.
- R2: An instruction with bit 15 = 0 loads bits 14..0 into the address register, zero-extended, and this shows on `mem_addr` after the edge. It never asserts `mem_we` and never changes the data register, whatever its other bits hold.
- R3: In a compute word (bits 15..13 = 111), bit 12 picks the ALU's second operand: 0 selects the address register and 1 selects `mem_rdata`. The data register is always the first operand.
- R4: Bits 11..6 of a compute word are, from high to low: clear first operand, invert first operand, clear second operand, invert second operand, add (1) or bitwise AND (0), and invert result. The clears act before the inversions. `mem_wdata` always shows the ALU result combinationally.
- R5: In a compute word, bit 5 loads the ALU result into the address register, bit 4 loads it into the data register, and bit 3 asserts `mem_we`.
- R6: In a compute word, bit 2 branches on a negative result (bit 15 set), bit 1 on a zero result, and bit 0 on a positive result (neither negative nor zero). A branch loads `pc_q` with the low 15 bits of the address register as it stood before the edge.
- R7: A compute word with bits 2..0 = 111, such as 16'hEA87, always branches.
- R8: Outside reset, when no branch is taken, `pc_q` advances by one each clock.
- R9: `mem_addr` is the low 15 bits of the current address register.
- R10: When the core fetches from an instruction store and uses a data store, a counting loop (increment a memory word until it equals a target word, then spin on a self-branch) leaves the word equal to the target. `pc_q` then alternates between the two spin addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word fetched at `pc_q` |
| mem_rdata | input | 16 | Data memory read value at `mem_addr` |
| mem_wdata | output | 16 | ALU result, data to write |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | 15 | Data memory address (address register) |
| pc_q | output | 15 | Program counter, address of the next instruction |

## Verification
The branch decision is the hardest part to reach from the ports. Each jump bit has to be met by a result of the matching sign, and also by a result of the other signs that must not branch. The second case needs the data register and the address register preloaded to known values first. The stimulus table therefore chains instructions: immediates and register moves set up the operands, and then conditional branches are issued against positive, zero and negative results. An immediate whose low bits mimic the destination and jump fields checks that non-compute words cannot write. A small counting program then runs from an instruction array to cover fetch-driven execution.

// File: rtl/acc16_pkg.sv
package acc16_pkg;

   // Field positions inside a compute word; the layout is fixed by the encoding.
   localparam int OPC_BIT  = 15;
   localparam int SRC_BIT  = 12;
   localparam int FN_HI    = 11;
   localparam int FN_LO    = 6;
   localparam int DST_A    = 5;
   localparam int DST_D    = 4;
   localparam int DST_M    = 3;
   localparam int JMP_HI   = 2;

   typedef struct packed {
      logic       is_c;     // compute word
      logic       sel_mem;  // second operand from memory
      logic       zx;
      logic       nx;
      logic       zy;
      logic       ny;
      logic       add;
      logic       inv_o;
      logic       ld_a;
      logic       ld_d;
      logic       wr_m;
      logic [2:0] jsel;     // {neg, zero, pos}
   } ctrl_t;

endpackage

// File: rtl/acc16_decode.sv
module acc16_decode
   import acc16_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0] instr,
   output ctrl_t         ctrl
);
   logic [5:0] fn;
   logic       is_c;
   logic       unused_fixed;

   assign is_c         = instr[OPC_BIT];
   assign fn           = instr[FN_HI:FN_LO];
   assign unused_fixed = ^instr[OPC_BIT-1:SRC_BIT+1];

   always_comb begin
      ctrl.is_c    = is_c;
      ctrl.sel_mem = instr[SRC_BIT];
      ctrl.zx      = fn[5];
      ctrl.nx      = fn[4];
      ctrl.zy      = fn[3];
      ctrl.ny      = fn[2];
      ctrl.add     = fn[1];
      ctrl.inv_o   = fn[0];
      // destination and branch fields only count in compute words
      ctrl.ld_a    = is_c & instr[DST_A];
      ctrl.ld_d    = is_c & instr[DST_D];
      ctrl.wr_m    = is_c & instr[DST_M];
      ctrl.jsel    = is_c ? instr[JMP_HI:0] : 3'b000;
   end
endmodule

// File: rtl/acc16_alu.sv
module acc16_alu
   import acc16_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0] opx,
   input  logic [DW-1:0] opy,
   input  ctrl_t         ctrl,
   output logic [DW-1:0] res,
   output logic          neg,
   output logic          zero
);
   logic [DW-1:0] x_z, x_p, y_z, y_p, raw;

   always_comb begin
      x_z = ctrl.zx ? '0 : opx;
      x_p = ctrl.nx ? ~x_z : x_z;
      y_z = ctrl.zy ? '0 : opy;
      y_p = ctrl.ny ? ~y_z : y_z;
      raw = ctrl.add ? (x_p + y_p) : (x_p & y_p);
      res = ctrl.inv_o ? ~raw : raw;
   end

   assign neg  = res[DW-1];
   assign zero = (res == '0);
endmodule

// File: rtl/acc16_pc.sv
module acc16_pc #(
   parameter int AW = 15
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [2:0]    jsel,
   input  logic          neg,
   input  logic          zero,
   input  logic [AW-1:0] target,
   output logic [AW-1:0] pc_q
);
   logic take;

   assign take = (jsel[2] & neg) | (jsel[1] & zero) | (jsel[0] & ~neg & ~zero);

   // priority: reset, then branch, then advance
   always_ff @(posedge clk) begin
      if (rst)       pc_q <= '0;
      else if (take) pc_q <= target;
      else           pc_q <= pc_q + 1'b1;
   end
endmodule

// File: rtl/acc16_core.sv
module acc16_core
   import acc16_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 15
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] instr,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [AW-1:0] pc_q
);
   localparam int IMM_W = DW - 1;

   generate
      if (DW != 16) begin : g_bad_dw
         $error("acc16_core: the word layout needs DW = 16");
      end
      if (AW > IMM_W || AW < 1) begin : g_bad_aw
         $error("acc16_core: AW must lie in 1..DW-1");
      end
   endgenerate

   ctrl_t         ctrl;
   logic [DW-1:0] a_q, d_q, opy, res;
   logic          neg, zero;

   acc16_decode #(.DW(DW)) u_dec (.instr(instr), .ctrl(ctrl));

   assign opy = ctrl.sel_mem ? mem_rdata : a_q;

   acc16_alu #(.DW(DW)) u_alu (
      .opx(d_q), .opy(opy), .ctrl(ctrl), .res(res), .neg(neg), .zero(zero)
   );

   acc16_pc #(.AW(AW)) u_pc (
      .clk(clk), .rst(rst), .jsel(ctrl.jsel), .neg(neg), .zero(zero),
      .target(a_q[AW-1:0]), .pc_q(pc_q)
   );

   always_ff @(posedge clk) begin
      if (rst)            a_q <= '0;
      else if (!ctrl.is_c) a_q <= {1'b0, instr[IMM_W-1:0]};
      else if (ctrl.ld_a) a_q <= res;
   end

   always_ff @(posedge clk) begin
      if (rst)            d_q <= '0;
      else if (ctrl.ld_d) d_q <= res;
   end

   assign mem_wdata = res;
   assign mem_we    = ctrl.wr_m & ~rst;
   assign mem_addr  = a_q[AW-1:0];
endmodule

// File: rtl/acc16_core_chk.sv
module acc16_core_chk #(
   parameter int DW = 16,
   parameter int AW = 15
) (
   input logic          clk,
   input logic          rst,
   input logic [DW-1:0] instr,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [AW-1:0] pc_q
);
   // R2: immediates never write memory
   a_r2_imm_no_write: assert property (@(posedge clk) disable iff (rst)
      !instr[DW-1] |-> !mem_we);

   // R2: immediate lands in the address register
   a_r2_imm_load: assert property (@(posedge clk) disable iff (rst)
      !instr[DW-1] |=> mem_addr == $past(instr[AW-1:0]));

   // R5: a write needs a compute word with the memory destination bit
   a_r5_write_src: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (instr[DW-1] && instr[3]));

   // R7: all jump bits set always branches to the address register
   a_r7_always_jump: assert property (@(posedge clk) disable iff (rst)
      (instr[DW-1] && instr[2:0] == 3'b111) |=> pc_q == $past(mem_addr));

   // R8: no jump bits means sequential advance
   a_r8_advance: assert property (@(posedge clk) disable iff (rst)
      (!instr[DW-1] || instr[2:0] == 3'b000) |=> pc_q == $past(pc_q) + 1'b1);
endmodule

bind acc16_core acc16_core_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst(rst), .instr(instr), .mem_we(mem_we),
   .mem_addr(mem_addr), .pc_q(pc_q)
);

// File: tb/acc16_core_test.sv
module acc16_core_test;
   localparam int N = 18;
   localparam int WATCH = 5000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        use_rom = 1'b0;
   logic [15:0] drv_instr = 16'h0000;
   logic [15:0] drv_rdata = 16'h0000;
   logic [15:0] instr, mem_rdata, mem_wdata;
   logic        mem_we;
   logic [14:0] mem_addr, pc_q;
   logic [15:0] rom [16];
   logic [15:0] ram [32];
   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   assign instr     = use_rom ? rom[pc_q[3:0]] : drv_instr;
   assign mem_rdata = use_rom ? ram[mem_addr[4:0]] : drv_rdata;

   always @(posedge clk) if (use_rom && mem_we) ram[mem_addr[4:0]] <= mem_wdata;

   acc16_core uut (
      .clk(clk), .rst(rst), .instr(instr), .mem_rdata(mem_rdata),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_addr(mem_addr), .pc_q(pc_q)
   );

   // entry: req, instr, rdata, wdata, check wdata, we, addr before edge, pc after edge
   typedef struct packed {
      logic [3:0]  req;
      logic [15:0] ins;
      logic [15:0] rd;
      logic [15:0] wd;
      logic        cw;
      logic        we;
      logic [14:0] ad;
      logic [14:0] pn;
   } vec_t;

   localparam vec_t VEC [N] = '{
      '{4'd2, 16'h0005, 16'h0000, 16'h0000, 1'b0, 1'b0, 15'd0,      15'd1},  // R2 A=5
      '{4'd4, 16'hEC10, 16'h0000, 16'h0005, 1'b1, 1'b0, 15'd5,      15'd2},  // R4 D=A
      '{4'd2, 16'h0003, 16'h0000, 16'h0000, 1'b0, 1'b0, 15'd5,      15'd3},  // R2 A=3
      '{4'd4, 16'hE4D0, 16'h0000, 16'h0002, 1'b1, 1'b0, 15'd3,      15'd4},  // R4 D=D-A
      '{4'd3, 16'hF088, 16'h0010, 16'h0012, 1'b1, 1'b1, 15'd3,      15'd5},  // R3 M=D+M
      '{4'd5, 16'hEEA8, 16'h0000, 16'hFFFF, 1'b1, 1'b1, 15'd3,      15'd6},  // R5 AM=-1
      '{4'd9, 16'h000A, 16'h0000, 16'h0000, 1'b0, 1'b0, 15'h7FFF,   15'd7},  // R9 addr=A low bits
      '{4'd6, 16'hE304, 16'h0000, 16'h0002, 1'b1, 1'b0, 15'd10,     15'd8},  // R6 positive, JLT no
      '{4'd6, 16'hE301, 16'h0000, 16'h0002, 1'b1, 1'b0, 15'd10,     15'd10}, // R6 positive, JGT yes
      '{4'd6, 16'hEA82, 16'h0000, 16'h0000, 1'b1, 1'b0, 15'd10,     15'd10}, // R6 zero, JEQ yes
      '{4'd6, 16'hEE84, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 15'd10,     15'd10}, // R6 negative, JLT yes
      '{4'd6, 16'hEE83, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 15'd10,     15'd11}, // R6 negative, JGE no
      '{4'd4, 16'hE350, 16'h0000, 16'hFFFD, 1'b1, 1'b0, 15'd10,     15'd12}, // R4 D=!D
      '{4'd4, 16'hE7C8, 16'h0000, 16'hFFFE, 1'b1, 1'b1, 15'd10,     15'd13}, // R4 M=D+1
      '{4'd4, 16'hE1C8, 16'h0000, 16'h000D, 1'b1, 1'b1, 15'd10,     15'd14}, // R4 M=A-D
      '{4'd7, 16'hEA87, 16'h0000, 16'h0000, 1'b1, 1'b0, 15'd10,     15'd10}, // R7 0;JMP
      '{4'd2, 16'h0038, 16'h0000, 16'h0000, 1'b0, 1'b0, 15'd10,     15'd11}, // R2 dest-like bits ignored
      '{4'd2, 16'hE308, 16'h0000, 16'hFFFD, 1'b1, 1'b1, 15'h38,     15'd12}  // R2 D kept, M=D
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(WATCH * 20);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      string rq;
      for (int i = 0; i < 16; i++) rom[i] = 16'h0000;
      for (int i = 0; i < 32; i++) ram[i] = 16'h0000;

      // R1: a writing instruction during reset must not strobe
      drv_instr = 16'hEEA8;
      repeat (3) @(negedge clk);
      #1 check(mem_we == 1'b0, "R1 we in reset", mem_we, 0);
      check(pc_q == 15'd0, "R1 pc", pc_q, 0);
      check(mem_addr == 15'd0, "R1 addr", mem_addr, 0);
      rst = 1'b0;

      for (int k = 0; k < N; k++) begin
         rq = $sformatf("R%0d vec %0d", VEC[k].req, k);
         drv_instr = VEC[k].ins;
         drv_rdata = VEC[k].rd;
         #1;
         if (VEC[k].cw) check(mem_wdata == VEC[k].wd, {rq, " wdata"}, mem_wdata, VEC[k].wd);
         check(mem_we == VEC[k].we, {rq, " we"}, mem_we, VEC[k].we);
         check(mem_addr == VEC[k].ad, {rq, " addr"}, mem_addr, VEC[k].ad);
         @(posedge clk);
         #1 check(pc_q == VEC[k].pn, {rq, " pc"}, pc_q, VEC[k].pn);
         @(negedge clk);
      end

      // R1: reset mid-run clears pc and address register
      drv_instr = 16'hEA87;
      rst = 1'b1;
      @(negedge clk);
      #1 check(pc_q == 15'd0, "R1 mid reset pc", pc_q, 0);
      check(mem_addr == 15'd0, "R1 mid reset addr", mem_addr, 0);
      check(mem_we == 1'b0, "R1 mid reset we", mem_we, 0);

      // R10: counting program from an instruction store
      rom[0]  = 16'h0010; rom[1]  = 16'hEA88; rom[2]  = 16'h0000; rom[3]  = 16'hFC10;
      rom[4]  = 16'h0010; rom[5]  = 16'hF4D0; rom[6]  = 16'h000C; rom[7]  = 16'hE302;
      rom[8]  = 16'h0010; rom[9]  = 16'hFDC8; rom[10] = 16'h0002; rom[11] = 16'hEA87;
      rom[12] = 16'h000C; rom[13] = 16'hEA87;
      ram[0]  = 16'd5;
      ram[16] = 16'h1234;
      use_rom = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      // R10 trace: straight line 0..11, then branch back to 2
      for (int c = 0; c <= 12; c++) begin
         #1 check(pc_q == ((c == 12) ? 15'd2 : 15'(c)), "R10 pc trace", pc_q,
                  (c == 12) ? 2 : c);
         @(negedge clk);
      end
      repeat (90) @(negedge clk);
      #1 check(ram[16] == 16'd5, "R10 counter word", ram[16], 5);
      check(ram[0] == 16'd5, "R10 target word", ram[0], 5);
      check(pc_q == 15'd12 || pc_q == 15'd13, "R10 spin pc", pc_q, 12);
      begin
         logic [14:0] p0;
         p0 = pc_q;
         @(negedge clk);
         #1 check(pc_q == ((p0 == 15'd12) ? 15'd13 : 15'd12), "R10 spin alternate",
                  pc_q, (p0 == 15'd12) ? 13 : 12);
      end
      finish_run();
   end
endmodule